// File: doc/BRIEF.md
# Serial Receiver with Deferred Overrun Reporting

This block turns an asynchronous serial line into bytes. It holds each byte in a receive data register and reports on it through a five-bit status word and one interrupt line. The line is sampled on an oversampling tick, normally sixteen ticks per bit. Each frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and a stop bit. A frame that arrives while the previous byte is still unread does not overwrite that byte. The overrun, and whether a line break caused it, stays hidden until software has taken the byte it was owed.

A consumer reads the data register by pulsing `dataRd` for one clock. When no overrun is waiting, that read clears the whole status word. When an overrun is waiting, the read brings the late character into the data register and shows the overrun. That character is not to be trusted, and a further read clears the error bits. The data-available interrupt can be masked on its own, so a DMA engine can collect the bytes while the error sources still interrupt the processor.

Top module: `rx_deferred_uart`

## Requirements
- R1: A falling line is taken as a start bit only if it is still low at the sample taken OSR/2 ticks later. A shorter low pulse produces no character and leaves data and status unchanged.
- R2: Status bit 0 (data available) and the data register take the new character on the same clock edge, the one at which the stop bit is sampled, never earlier. Data bits are assembled least significant bit first.
- R3: With `rdaIrqDis` high, data available alone does not raise `irq`. Any error bit still raises it.
- R4: If a character completes while status bit 0 is already 1, the data register and the status word keep their values. Overrun (bit 1) and the break of the new character (bit 2) stay hidden.
- R5: A data read made while an overrun is waiting loads the newest late character, and sets bit 0 and bit 1. Bit 2 shows whether that character was a break.
- R6: A line held low through the whole frame, stop bit included, gives data 0x00 with bit 2 (break) and bit 3 (framing) set. No new start is accepted until the line has been seen high again.
- R7: A stop bit sampled low sets bit 3 for that character.
- R8: When `parityEn` is high, one parity bit follows the data. `parityOdd` = 0 expects an even number of ones over data and parity, and 1 expects an odd number. A mismatch sets bit 4.
- R9: `irq` is high whenever any of status bits 1 to 4 is set, or when bit 0 is set and `rdaIrqDis` is low.
- R10: A data read with no overrun waiting clears status bits 0 to 4. If a character completes on the edge of that read, the new character is loaded with bit 0 set and no overrun.
- R11: After reset the data register is 0x00, the status word is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversampling enable, OSR pulses per bit |
| rxLine | input | 1 | Serial line input, idle high |
| parityEn | input | 1 | A parity bit follows the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rdaIrqDis | input | 1 | Masks the data-available interrupt source |
| dataRd | input | 1 | One-cycle strobe that reads the data register |
| rxData | output | DATA_W | Receive data register |
| rxStatus | output | 5 | {parity, framing, break, overrun, available} |
| irq | output | 1 | Combined interrupt |

## Verification
On every clock the assertions check these rules:
- A held byte stays stable while it is unread.
- A visible overrun always comes with data available.
- A read with an overrun waiting brings the overrun into view, and a plain read clears the status word.
- Data available rises only after a stop-bit sample.
- The interrupt follows the error bits and the mask.

Other behaviour depends on the serial timing, so only the bench scenarios show it: rejection of a start glitch, the parity and framing results for particular frames, which late character wins an overrun, a break hidden behind an overrun, recovery after a break, and a read that lands on the very edge where a frame completes.

// File: rtl/rx_uart_pkg.sv
package rx_uart_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cntClr;
    logic shiftEn;
    logic parCap;
    logic frameDone;
  } rxStrobe_t;

  // visible status word, bit 0 is the least significant field
  typedef struct packed {
    logic parity;
    logic framing;
    logic brk;
    logic overrun;
    logic avail;
  } rxStatus_t;

endpackage

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  rxStrobe_t         strb,
  output logic              lineS,
  output logic              midHit,
  output logic              endHit,
  output logic              lastBit,
  output logic [DATA_W-1:0] frmData,
  output logic              frmFe,
  output logic              frmPe,
  output logic              frmBrk
);

  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              syncA;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg;
  logic              parBit;

  // two-stage synchroniser, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
    end else begin
      syncA <= rxLine;
      lineS <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (sampleTick) begin
      if (strb.cntClr) tickCnt <= '0;
      else             tickCnt <= tickCnt + 1'b1;
    end
  end

  assign midHit  = (tickCnt == CNT_W'(OSR / 2 - 1));
  assign endHit  = (tickCnt == CNT_W'(OSR - 1));
  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (strb.shiftEn) begin
        shReg  <= {lineS, shReg[DATA_W-1:1]};
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strb.parCap) parBit <= lineS;
    end
  end

  // frame results, meaningful while frameDone is strobed
  assign frmData = shReg;
  assign frmFe   = ~lineS;
  assign frmPe   = parityEn & ((^{shReg, parBit}) != parityOdd);
  assign frmBrk  = frmFe & (shReg == '0) & (~parityEn | ~parBit);

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_uart_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineS,
  input  logic      midHit,
  input  logic      endHit,
  input  logic      lastBit,
  input  logic      parityEn,
  output rxStrobe_t strb
);

  rxState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (sampleTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!lineS) begin
            strb.cntClr = 1'b1;
            stateNext   = ST_START;
          end
        end
        ST_START: begin
          if (midHit) begin
            strb.cntClr = 1'b1;
            stateNext   = lineS ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (endHit) begin
            strb.cntClr  = 1'b1;
            strb.shiftEn = 1'b1;
            if (lastBit) stateNext = parityEn ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (endHit) begin
            strb.cntClr = 1'b1;
            strb.parCap = 1'b1;
            stateNext   = ST_STOP;
          end
        end
        ST_STOP: begin
          if (endHit) begin
            strb.cntClr    = 1'b1;
            strb.frameDone = 1'b1;
            stateNext      = lineS ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lineS) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import rx_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frmData,
  input  logic              frmFe,
  input  logic              frmPe,
  input  logic              frmBrk,
  input  logic              dataRd,
  input  logic              rdaIrqDis,
  output logic [DATA_W-1:0] heldData,
  output rxStatus_t         sts,
  output logic              ovrPend,
  output logic              irq
);

  logic [DATA_W-1:0] shData;
  logic              shFe, shPe, shBrk;
  logic              availAfterRd;

  assign availAfterRd = dataRd ? ovrPend : sts.avail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      sts      <= '0;
      ovrPend  <= 1'b0;
      shData   <= '0;
      shFe     <= 1'b0;
      shPe     <= 1'b0;
      shBrk    <= 1'b0;
    end else begin
      if (dataRd) begin
        if (ovrPend) begin
          heldData    <= shData;
          sts.avail   <= 1'b1;
          sts.overrun <= 1'b1;
          sts.brk     <= shBrk;
          sts.framing <= shFe;
          sts.parity  <= shPe;
          ovrPend     <= 1'b0;
        end else begin
          sts <= '0;
        end
      end
      if (frameDone) begin
        if (availAfterRd) begin
          ovrPend <= 1'b1;
          shData  <= frmData;
          shFe    <= frmFe;
          shPe    <= frmPe;
          shBrk   <= frmBrk;
        end else begin
          heldData    <= frmData;
          sts.avail   <= 1'b1;
          sts.overrun <= 1'b0;
          sts.brk     <= frmBrk;
          sts.framing <= frmFe;
          sts.parity  <= frmPe;
        end
      end
    end
  end

  assign irq = (sts.avail & ~rdaIrqDis) | sts.overrun | sts.brk | sts.framing | sts.parity;

endmodule

// File: rtl/rx_deferred_uart.sv
module rx_deferred_uart
  import rx_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rdaIrqDis,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rxData,
  output logic [4:0]        rxStatus,
  output logic              irq
);

  rxStrobe_t         strb;
  rxStatus_t         stsW;
  logic              lineS, midHit, endHit, lastBit;
  logic [DATA_W-1:0] frmData;
  logic              frmFe, frmPe, frmBrk;
  logic              frameDoneW;
  logic              ovrPendW;

  rx_datapath #(.DATA_W(DATA_W), .OSR(OSR)) dp_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .strb(strb),
    .lineS(lineS), .midHit(midHit), .endHit(endHit), .lastBit(lastBit),
    .frmData(frmData), .frmFe(frmFe), .frmPe(frmPe), .frmBrk(frmBrk)
  );

  rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineS(lineS),
    .midHit(midHit), .endHit(endHit), .lastBit(lastBit),
    .parityEn(parityEn), .strb(strb)
  );

  assign frameDoneW = strb.frameDone;

  rx_holding #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rstN(rstN), .frameDone(frameDoneW), .frmData(frmData),
    .frmFe(frmFe), .frmPe(frmPe), .frmBrk(frmBrk), .dataRd(dataRd),
    .rdaIrqDis(rdaIrqDis), .heldData(rxData), .sts(stsW),
    .ovrPend(ovrPendW), .irq(irq)
  );

  assign rxStatus = stsW;

endmodule

// File: rtl/rx_deferred_uart_chk.sv
module rx_deferred_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataRd,
  input logic              rdaIrqDis,
  input logic [DATA_W-1:0] rxData,
  input logic [4:0]        rxStatus,
  input logic              irq,
  input logic              frameDoneW,
  input logic              ovrPendW
);

  // held byte is protected while unread
  assert_held_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxStatus[0] && !dataRd) |=> ($stable(rxData) && rxStatus[0]));

  // a visible overrun always comes with data available
  assert_ovr_with_avail_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxStatus[1] |-> rxStatus[0]);

  assert_deferred_reveal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && ovrPendW) |=> (rxStatus[1] && rxStatus[0]));

  assert_plain_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !ovrPendW && !frameDoneW) |=> (rxStatus == 5'b0));

  assert_avail_after_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxStatus[0]) |-> $past(frameDoneW));

  assert_error_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|rxStatus[4:1]) |-> irq);

  assert_mask_only_avail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdaIrqDis && rxStatus[4:1] == 4'b0) |-> !irq);

endmodule

bind rx_deferred_uart rx_deferred_uart_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .dataRd(dataRd), .rdaIrqDis(rdaIrqDis),
  .rxData(rxData), .rxStatus(rxStatus), .irq(irq),
  .frameDoneW(frameDoneW), .ovrPendW(ovrPendW)
);

// File: tb/rx_deferred_uart_tb.sv
module rx_deferred_uart_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rdaIrqDis = 1'b0;
  logic       dataRd = 1'b0;
  logic [7:0] rxData;
  logic [4:0] rxStatus;
  logic       irq;

  int nVec = 0;
  int nErr = 0;
  int cycles = 0;

  // reference model state
  logic [7:0]  mData = '0;
  logic        mAvail = 0, mOvr = 0, mBrk = 0, mFe = 0, mPe = 0;
  int unsigned pendQ[$];
  logic [7:0]  fData;
  logic        fFe, fPe, fBrk;
  bit          armed = 0;
  int          frameCyc = 0;
  int          doneAt = 154;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_deferred_uart dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdaIrqDis(rdaIrqDis),
    .dataRd(dataRd), .rxData(rxData), .rxStatus(rxStatus), .irq(irq)
  );

  function automatic logic [4:0] expSts();
    return {mPe, mFe, mBrk, mOvr, mAvail};
  endfunction

  function automatic logic expIrq();
    return (mAvail && !rdaIrqDis) || mOvr || mBrk || mFe || mPe;
  endfunction

  // behavioural model, updated on the same edge as the design
  always @(posedge clk) begin
    if (!rstN) begin
      mData = '0; mAvail = 0; mOvr = 0; mBrk = 0; mFe = 0; mPe = 0;
      pendQ.delete();
    end else begin
      bit done;
      int unsigned e;
      done = 0;
      if (armed) begin
        frameCyc++;
        if (frameCyc == doneAt) begin done = 1; armed = 0; end
      end
      if (dataRd) begin
        if (pendQ.size() > 0) begin
          e = pendQ.pop_front();
          mData = e[7:0]; mFe = e[8]; mPe = e[9]; mBrk = e[10];
          mAvail = 1; mOvr = 1;
        end else begin
          mAvail = 0; mOvr = 0; mBrk = 0; mFe = 0; mPe = 0;
        end
      end
      if (done) begin
        if (mAvail) begin
          pendQ.delete();
          pendQ.push_back({21'd0, fBrk, fPe, fFe, fData});
        end else begin
          mData = fData; mAvail = 1; mOvr = 0; mBrk = fBrk; mFe = fFe; mPe = fPe;
        end
      end
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      nVec++;
      if (rxData !== mData) begin
        nErr++; $display("FAIL R4 rxData actual %h expected %h", rxData, mData);
      end
      if (rxStatus[0] !== mAvail) begin
        nErr++; $display("FAIL R2 avail actual %b expected %b", rxStatus[0], mAvail);
      end
      if (rxStatus[1] !== mOvr) begin
        nErr++; $display("FAIL R5 overrun actual %b expected %b", rxStatus[1], mOvr);
      end
      if (rxStatus[2] !== mBrk) begin
        nErr++; $display("FAIL R6 break actual %b expected %b", rxStatus[2], mBrk);
      end
      if (rxStatus[3] !== mFe) begin
        nErr++; $display("FAIL R7 framing actual %b expected %b", rxStatus[3], mFe);
      end
      if (rxStatus[4] !== mPe) begin
        nErr++; $display("FAIL R8 parity actual %b expected %b", rxStatus[4], mPe);
      end
      if (irq !== expIrq()) begin
        nErr++; $display("FAIL R9 irq actual %b expected %b", irq, expIrq());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nErr++;
      $display("FAIL watchdog actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  // scenario check against values written from the requirements
  task automatic chk(input string tag, input logic [7:0] eData,
                     input logic [4:0] eSts, input logic eIrq);
    nVec++;
    if (rxData !== eData || rxStatus !== eSts || irq !== eIrq) begin
      nErr++;
      $display("FAIL %s actual data %h sts %b irq %b expected data %h sts %b irq %b",
               tag, rxData, rxStatus, irq, eData, eSts, eIrq);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic slot(input logic v);
    rxLine = v;
    repeat (16) @(negedge clk);
  endtask

  // one frame: start, 8 data LSB first, optional parity, stop
  task automatic sendFrame(input logic [7:0] d, input bit badPar,
                           input bit stopLow, input bit brk);
    logic [7:0] sd;
    logic       sp, ss;
    sd = brk ? 8'h00 : d;
    sp = parityOdd ? ~^sd : ^sd;
    if (badPar) sp = ~sp;
    if (brk) sp = 1'b0;
    ss = !(stopLow || brk);
    fData = sd;
    fFe   = !ss;
    fPe   = parityEn && ((^{sd, sp}) != parityOdd);
    fBrk  = !ss && (sd == 8'h00) && (!parityEn || !sp);
    doneAt = 154 + (parityEn ? 16 : 0);
    @(negedge clk);
    frameCyc = -1;
    armed = 1;
    slot(1'b0);
    for (int i = 0; i < 8; i++) slot(sd[i]);
    if (parityEn) slot(sp);
    slot(ss);
    rxLine = 1'b1;
    #2;
  endtask

  task automatic readData();
    @(negedge clk);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
    #2;
  endtask

  initial begin
    idle(5);
    chk("R11 reset state", 8'h00, 5'b00000, 1'b0);
    rstN = 1'b1;
    idle(20);

    // plain frame
    sendFrame(8'hA5, 0, 0, 0);
    chk("R2 byte A5 available", 8'hA5, 5'b00001, 1'b1);
    readData();
    chk("R10 read clears status", 8'hA5, 5'b00000, 1'b0);

    // masked data interrupt, then framing error under mask
    rdaIrqDis = 1'b1;
    sendFrame(8'h5A, 0, 0, 0);
    chk("R3 avail masked", 8'h5A, 5'b00001, 1'b0);
    readData();
    sendFrame(8'h81, 0, 1, 0);
    chk("R7 framing error, R3 not masked", 8'h81, 5'b01001, 1'b1);
    readData();
    rdaIrqDis = 1'b0;

    // parity
    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h3C, 0, 0, 0);
    chk("R8 even parity good", 8'h3C, 5'b00001, 1'b1);
    readData();
    sendFrame(8'h3C, 1, 0, 0);
    chk("R8 even parity bad", 8'h3C, 5'b10001, 1'b1);
    readData();
    parityOdd = 1'b1;
    sendFrame(8'h07, 0, 0, 0);
    chk("R8 odd parity good", 8'h07, 5'b00001, 1'b1);
    readData();
    sendFrame(8'h07, 1, 0, 0);
    chk("R8 odd parity bad", 8'h07, 5'b10001, 1'b1);
    readData();
    parityEn = 1'b0; parityOdd = 1'b0;

    // overrun
    sendFrame(8'h11, 0, 0, 0);
    sendFrame(8'h22, 0, 0, 0);
    sendFrame(8'h33, 0, 0, 0);
    chk("R4 held byte kept, overrun hidden", 8'h11, 5'b00001, 1'b1);
    readData();
    chk("R5 late byte with overrun", 8'h33, 5'b00011, 1'b1);
    readData();
    chk("R10 second read clears errors", 8'h33, 5'b00000, 1'b0);

    // overrun caused by a break
    sendFrame(8'h44, 0, 0, 0);
    sendFrame(8'h00, 0, 0, 1);
    idle(3);
    chk("R4 break hidden behind held byte", 8'h44, 5'b00001, 1'b1);
    readData();
    chk("R5 R6 overrun by break", 8'h00, 5'b01111, 1'b1);
    readData();
    chk("R10 cleared after break overrun", 8'h00, 5'b00000, 1'b0);

    // standalone break then recovery
    sendFrame(8'h00, 0, 0, 1);
    idle(3);
    chk("R6 break flags", 8'h00, 5'b01101, 1'b1);
    readData();
    sendFrame(8'h96, 0, 0, 0);
    chk("R6 receive after break", 8'h96, 5'b00001, 1'b1);
    readData();

    // short low pulse
    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    idle(200);
    chk("R1 glitch ignored", 8'h96, 5'b00000, 1'b0);

    // read on the very edge a frame completes
    sendFrame(8'h18, 0, 0, 0);
    fork
      sendFrame(8'hC3, 0, 0, 0);
      begin
        repeat (155) @(negedge clk);
        dataRd = 1'b1;
        @(negedge clk);
        dataRd = 1'b0;
      end
    join
    idle(2);
    chk("R10 coincident read and completion", 8'hC3, 5'b00001, 1'b1);
    readData();
    idle(10);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

endmodule